// File: doc/BRIEF.md
# Programmable Parallel I/O Controller

This block lets a host drive and sample three 8-bit parallel ports, called A, B and C. The host reaches it over a simple register bus made of a select, a 2-bit register address, read and write strobes, and separate 8-bit write-data and read-data buses. The ports are split into two groups. The first group is port A plus the upper nibble of port C. The second group is port B plus the lower nibble of port C. Each group half has its own direction, and each group has its own operating mode.

A single command register address accepts two kinds of word, and bit 7 tells them apart. The first kind reprograms the modes and directions of both groups and clears every output latch. The second kind changes one bit of the port C latch. In basic mode an output port holds the last value written and drives it, and an input port returns its live pins when read. The handshaking modes are carried out by a separate channel block. This controller only stores the selected mode and presents it to that block.

Writes take effect on the rising clock edge. Reads are combinational while select and read are both high.

Top module: `ppio_ctrl`

## Requirements
- R1: While `sel` is low, a write changes no latch and no configuration, and `rdata` is 0. `rdata` is also 0 whenever `rd` is low.
- R2: The register address picks the target: 2'b00 is port A, 2'b01 is port B, 2'b10 is port C and 2'b11 is the command register.
- R3: A command write with bit 7 = 1 is a configuration word. Bit 4 sets the port A direction, bit 3 the port C upper-nibble direction, bit 1 the port B direction and bit 0 the port C lower-nibble direction, where 1 means input. Each bit of the output-enable vectors is the inverse of its direction: `pa_oe`, `pb_oe`, `pc_oe[7:4]` and `pc_oe[3:0]`.
- R4: In a configuration word, bits 6..5 set the group A mode: 2'b00 gives mode 0, 2'b01 gives mode 1, and 2'b10 or 2'b11 give mode 2, so `grp_a_mode` is never 3. Bit 2 sets the group B mode, 0 or 1.
- R5: A configuration word clears the A, B and C output latches to zero.
- R6: A command write with bit 7 = 0 writes bit 0 into the port C latch bit indexed by bits 3..1. All other latch bits stay unchanged, and so does the configuration.
- R7: Reading a port set as output returns its latch. Reading a port set as input returns its pins. Port C applies this separately to each nibble.
- R8: Reading the command register address returns 0.
- R9: After reset all ports are inputs, both modes are 0 and all latches are 0.
- R10: A data write to a port updates its latch (`pX_out`) whatever the direction. The output enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Device select, active high |
| addr | input | 2 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| pa_in | input | 8 | Port A pin levels |
| pb_in | input | 8 | Port B pin levels |
| pc_in | input | 8 | Port C pin levels |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_oe | output | 8 | Port C per-bit output enable |
| grp_a_mode | output | 2 | Group A mode (0, 1, 2) |
| grp_b_mode | output | 1 | Group B mode (0, 1) |

## Verification
A host read and a host write can fall in the same cycle, because the read path is combinational and the write lands at the clock edge. The bench raises `rd` and `wr` together on port A while that port is an output. It expects the pre-edge latch on `rdata` during that cycle and the new value once the edge has passed. A single-bit port C write that lands on a nibble set as input is a second overlap. The bench judges that case by checking that `pc_out` moves while the read of that nibble still returns the pins.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  localparam int PW = 8;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_dir;   // 1 = input
    logic       cu_dir;
    logic       b_mode;
    logic       b_dir;
    logic       cl_dir;
  } ppio_cfg_t;

  localparam ppio_cfg_t CFG_RESET = '{a_mode: 2'd0, a_dir: 1'b1, cu_dir: 1'b1,
                                     b_mode: 1'b0, b_dir: 1'b1, cl_dir: 1'b1};

  function automatic logic [1:0] grp_a_mode_of(input logic [1:0] fld);
    return fld[1] ? 2'd2 : {1'b0, fld[0]};
  endfunction

  function automatic ppio_cfg_t cfg_of(input logic [7:0] w);
    ppio_cfg_t c;
    c.a_mode = grp_a_mode_of(w[6:5]);
    c.a_dir  = w[4];
    c.cu_dir = w[3];
    c.b_mode = w[2];
    c.b_dir  = w[1];
    c.cl_dir = w[0];
    return c;
  endfunction

  function automatic logic [7:0] mix_read(input logic [7:0] latch, input logic [7:0] pins,
                                          input logic [7:0] oe);
    return (latch & oe) | (pins & ~oe);
  endfunction
endpackage

// File: rtl/ppio_cmd_dec.sv
module ppio_cmd_dec
  import ppio_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            cmd_wr,
  input  logic [7:0]      wdata,
  output logic            cfg_wr,
  output logic            bit_wr,
  output logic [IDXW-1:0] bit_idx,
  output logic            bit_val,
  output ppio_cfg_t       cfg_nxt
);
  always_comb begin
    cfg_wr  = cmd_wr & wdata[7];
    bit_wr  = cmd_wr & ~wdata[7];
    bit_idx = wdata[IDXW:1];
    bit_val = wdata[0];
    cfg_nxt = cfg_of(wdata);
  end
endmodule

// File: rtl/ppio_port.sv
module ppio_port #(
  parameter int W    = 8,
  parameter bit HAS_BIT = 1'b0,
  localparam int IW  = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  logic          bit_en,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  q
);
  logic [W-1:0] q_nxt;

  generate
    if (HAS_BIT) begin : g_bit
      always_comb begin
        q_nxt = q;
        if (clr)         q_nxt = '0;
        else if (wr_en)  q_nxt = wdata;
        else if (bit_en) q_nxt[bit_idx] = bit_val;
      end
    end else begin : g_nobit
      always_comb begin
        q_nxt = q;
        if (clr)        q_nxt = '0;
        else if (wr_en) q_nxt = wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= q_nxt;

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == '0);

  generate
    if (HAS_BIT) begin : g_chk
      assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !wr_en) |=> ($countones(q ^ $past(q)) <= 1)
                                        && (q[$past(bit_idx)] == $past(bit_val)));
    end
  endgenerate
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic [1:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  input  logic [7:0] pb_in,
  input  logic [7:0] pc_in,
  output logic [7:0] pa_out,
  output logic [7:0] pb_out,
  output logic [7:0] pc_out,
  output logic [7:0] pa_oe,
  output logic [7:0] pb_oe,
  output logic [7:0] pc_oe,
  output logic [1:0] grp_a_mode,
  output logic       grp_b_mode
);
  localparam int IW = $clog2(PW);
  localparam int HW = PW / 2;

  logic      host_wr, cmd_wr, cfg_wr, bit_wr, bit_val;
  logic [IW-1:0] bit_idx;
  ppio_cfg_t cfg_q, cfg_nxt;

  assign host_wr = sel & wr;
  assign cmd_wr  = host_wr & (addr == 2'b11);

  ppio_cmd_dec #(.IDXW(IW)) u_dec (
    .cmd_wr(cmd_wr), .wdata(wdata), .cfg_wr(cfg_wr), .bit_wr(bit_wr),
    .bit_idx(bit_idx), .bit_val(bit_val), .cfg_nxt(cfg_nxt));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_wr) cfg_q <= cfg_nxt;

  ppio_port #(.W(PW), .HAS_BIT(1'b0)) u_pa (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .wr_en(host_wr && addr == 2'b00),
    .wdata(wdata), .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out));
  ppio_port #(.W(PW), .HAS_BIT(1'b0)) u_pb (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .wr_en(host_wr && addr == 2'b01),
    .wdata(wdata), .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out));
  ppio_port #(.W(PW), .HAS_BIT(1'b1)) u_pc (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .wr_en(host_wr && addr == 2'b10),
    .wdata(wdata), .bit_en(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val), .q(pc_out));

  assign pa_oe      = {PW{~cfg_q.a_dir}};
  assign pb_oe      = {PW{~cfg_q.b_dir}};
  assign pc_oe      = {{HW{~cfg_q.cu_dir}}, {HW{~cfg_q.cl_dir}}};
  assign grp_a_mode = cfg_q.a_mode;
  assign grp_b_mode = cfg_q.b_mode;

  always_comb begin
    rdata = '0;
    if (sel && rd) begin
      unique case (addr)
        2'b00: rdata = mix_read(pa_out, pa_in, pa_oe);
        2'b01: rdata = mix_read(pb_out, pb_in, pb_oe);
        2'b10: rdata = mix_read(pc_out, pc_in, pc_oe);
        default: rdata = '0;
      endcase
    end
  end

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd) |-> rdata == '0);
  assert_no_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pa_oe));
  assert_dir_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> pa_oe == {PW{~$past(wdata[4])}} && pb_oe == {PW{~$past(wdata[1])}});
  assert_mode_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grp_a_mode != 2'd3);
  assert_bit_keeps_cfg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr |=> $stable(pc_oe) && $stable(grp_a_mode));
  assert_cmd_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && rd && addr == 2'b11) |-> rdata == '0);
endmodule

// File: tb/ppio_ctrl_tb.sv
module ppio_ctrl_tb;
  logic clk = 0, rst_n = 0, sel = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe;
  logic [1:0] grp_a_mode;
  logic grp_b_mode;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ppio_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; rd = 0; addr = a; wdata = d;
    @(posedge clk); #1; sel = 0; wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); sel = 1; rd = 1; wr = 0; addr = a;
    #1 chk(tag, rdata, exp);
    sel = 0; rd = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] e_pc;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
    chk("R9 latch", {pa_out, pb_out, pc_out}, 24'h0);
    chk("R9 mode", {grp_a_mode, grp_b_mode}, 3'd0);
    rst_n = 1;

    // R3 R4 R5: sweep every configuration word
    for (int m = 0; m < 128; m++) begin
      logic [7:0] w;
      w = 8'h80 | m[7:0];
      wr_reg(2'b00, 8'hA5); wr_reg(2'b01, 8'h5A); wr_reg(2'b10, 8'hC3);
      wr_reg(2'b11, w);
      chk("R3 pa_oe", pa_oe, {8{~w[4]}});
      chk("R3 pb_oe", pb_oe, {8{~w[1]}});
      chk("R3 pc_oe", pc_oe, {{4{~w[3]}}, {4{~w[0]}}});
      chk("R4 a_mode", grp_a_mode, w[6] ? 2'd2 : {1'b0, w[5]});
      chk("R4 b_mode", grp_b_mode, w[2]);
      chk("R5 clear", {pa_out, pb_out, pc_out}, 24'h0);
    end

    // R6 single-bit writes to port C, all outputs
    wr_reg(2'b11, 8'h80);
    e_pc = 8'h00;
    for (int i = 0; i < 16; i++) begin
      logic [2:0] idx;
      logic v;
      idx = i[2:0]; v = ~i[3];
      wr_reg(2'b11, {4'b0, idx, v});
      e_pc[idx] = v;
      chk("R6 bit", pc_out, e_pc);
      chk("R6 cfg kept", pc_oe, 8'hFF);
    end

    // R2 R7: outputs read latch
    wr_reg(2'b00, 8'h11); wr_reg(2'b01, 8'h22); wr_reg(2'b10, 8'h33);
    pa_in = 8'hEE; pb_in = 8'hDD; pc_in = 8'hCC;
    rd_chk(2'b00, 8'h11, "R2 R7 A out");
    rd_chk(2'b01, 8'h22, "R2 R7 B out");
    rd_chk(2'b10, 8'h33, "R2 R7 C out");
    rd_chk(2'b11, 8'h00, "R8 cmd read");

    // same-cycle read and write on port A
    @(negedge clk); sel = 1; rd = 1; wr = 1; addr = 2'b00; wdata = 8'h7E;
    #1 chk("R7 rd-before-edge", rdata, 8'h11);
    @(posedge clk); #1 chk("R7 rd-after-edge", rdata, 8'h7E);
    sel = 0; rd = 0; wr = 0;

    // R7 inputs read pins; R10 latch still written
    wr_reg(2'b11, 8'h9B);
    for (int p = 0; p < 256; p += 37) begin
      pa_in = p[7:0]; pb_in = ~p[7:0]; pc_in = p[7:0] ^ 8'h5A;
      rd_chk(2'b00, p[7:0], "R7 A in");
      rd_chk(2'b01, ~p[7:0], "R7 B in");
      rd_chk(2'b10, p[7:0] ^ 8'h5A, "R7 C in");
    end
    wr_reg(2'b00, 8'h96);
    chk("R10 latch", pa_out, 8'h96);
    chk("R10 oe", pa_oe, 8'h00);

    // R7 mixed port C: upper input, lower output
    wr_reg(2'b11, 8'h88);
    wr_reg(2'b10, 8'h0F);
    pc_in = 8'hA0;
    rd_chk(2'b10, 8'hAF, "R7 C mixed");
    wr_reg(2'b11, 8'h0E);  // bit 7 <- 0 on an input nibble
    chk("R6 latch on input nibble", pc_out, 8'h0F);
    wr_reg(2'b11, 8'h0F);
    chk("R6 set bit7", pc_out, 8'h8F);
    rd_chk(2'b10, 8'hAF, "R7 C pins kept");

    // R1 unselected writes ignored
    @(negedge clk); sel = 0; wr = 1; addr = 2'b10; wdata = 8'h00;
    @(posedge clk); #1 wr = 0;
    chk("R1 no write", pc_out, 8'h8F);
    @(negedge clk); sel = 0; wr = 1; addr = 2'b11; wdata = 8'h80;
    @(posedge clk); #1 wr = 0;
    chk("R1 no cfg", pc_oe, 8'h0F);
    @(negedge clk); sel = 0; rd = 1; addr = 2'b10;
    #1 chk("R1 rdata idle", rdata, 8'h00);
    rd = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule